// File: doc/BRIEF.md
# Display Refresh DMA Channel Control Registers

This block is the register set that steers one display refresh DMA channel. Software reaches it through a simple synchronous register bus with eight 16-bit locations. It reads back combinationally and writes on the clock edge. An address generator outside the block consumes the channel's active parameters: the start address, the element count and the frame count. It also sees a transfer-go level. When it has finished a block it returns a one-cycle done pulse.

The frame parameters are double-buffered. Software writes a programmed set at any time and then sets the end-of-programming request in the channel control register. If the channel is idle, the programmed set is copied into the active set at once. If the channel is running, the request is held and then serviced on the next block-done pulse, which keeps a frame from being torn mid-block. When the repeat pair is set, a completed block leaves the channel running so the display refreshes with no software help. Without it, the channel stops after one block. A block-complete status bit drives an interrupt line through an enable bit.

Top module: `dchan_ctl`

## Requirements
- R1: After reset, channel control reads 0x5440, display control reads 0x0000, data parameter reads 0x9102, logical channel control reads 0x0004, the active set is all zero, and xfer_go and irq are 0.
- R2: Register offsets are: 0 channel control, 1 display control, 2 data parameter, 3 logical channel control, 4 base address low half, 5 base address high half, 6 element count, 7 frame count. Offsets 2 to 7 read back the last value written.
- R3: xfer_go is 1 exactly when channel control bit 7 (enable), channel control bit 0 (claim) and display control bit 8 (external controller enable) are all 1.
- R4: Writing channel control with bit 11 set while the channel is not running (bit 7 and bit 0 not both 1 before the write) copies offsets 4 to 7 into the active set at that edge, and bit 11 then reads 0. Without such a load, the active set does not change.
- R5: Writing bit 11 while running leaves the active set unchanged and bit 11 reading 1 until the next blk_done. On that pulse the programmed set is copied and bit 11 clears.
- R6: With channel control bits 9:8 equal to 11 (repeat), blk_done while running leaves bit 7 set.
- R7: With bits 9:8 not equal to 11, blk_done while running clears bit 7, ending the transfer after one block.
- R8: Display control bit 3 is the block-complete status. It is set by every blk_done, cleared by writing 1 to bit 3, unchanged by writing 0, and a set in the same cycle as a clear wins.
- R9: irq equals display control bit 3 AND display control bit 1 (interrupt enable).
- R10: Clearing channel control bit 0 stops the channel: xfer_go drops, and a later blk_done does not alter channel control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, with bus_sel |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| blk_done | input | 1 | One-cycle block-complete pulse from the address generator |
| xfer_go | output | 1 | Channel may move data |
| act_base | output | 32 | Active start address |
| act_ecnt | output | 16 | Active element count |
| act_fcnt | output | 16 | Active frame count |
| irq | output | 1 | Block-complete interrupt |

## Verification
Every write and every blk_done pulse takes effect at the rising edge that samples it. Read data, xfer_go, irq and the active set are all one register away from that edge. Results are therefore due one cycle after the stimulus. The bench drives stimulus on the falling edge and samples a quarter period after the following falling edge, so each check lands on the cycle the effect is due. Entries that check a held request are placed between the write and the done pulse, so they catch a load that happens one cycle early.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    RA_CHAN    = 3'd0,
    RA_DISP    = 3'd1,
    RA_DPRM    = 3'd2,
    RA_LCHN    = 3'd3,
    RA_BASE_LO = 3'd4,
    RA_BASE_HI = 3'd5,
    RA_ECNT    = 3'd6,
    RA_FCNT    = 3'd7
  } reg_addr_e;

  // channel control bit positions
  localparam int CC_CLAIM = 0;
  localparam int CC_EN    = 7;
  localparam int CC_RPT0  = 8;
  localparam int CC_RPT1  = 9;
  localparam int CC_EOP   = 11;
  // display control bit positions
  localparam int DC_IE  = 1;
  localparam int DC_ST  = 3;
  localparam int DC_EXT = 8;

  localparam logic [DW-1:0] RST_CHAN = 16'h5440;
  localparam logic [DW-1:0] RST_DPRM = 16'h9102;
  localparam logic [DW-1:0] RST_LCHN = 16'h0004;

  function automatic logic f_running(logic [DW-1:0] cc);
    return cc[CC_EN] & cc[CC_CLAIM];
  endfunction

  function automatic logic f_repeat(logic [DW-1:0] cc);
    return cc[CC_RPT1] & cc[CC_RPT0];
  endfunction

  // status: set dominates a write-one clear
  function automatic logic f_status_next(logic cur, logic clr, logic set);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dchan_chan.sv
module dchan_chan
  import dchan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          blk_done,
  output logic [DW-1:0] ccr_q,
  output logic          running,
  output logic          load_now
);
  logic [DW-1:0] ccr_d;
  logic          pend, rpt, idle_load, done_load;

  assign running   = f_running(ccr_q);
  assign rpt       = f_repeat(ccr_q);
  assign pend      = ccr_q[CC_EOP];
  assign idle_load = wr_en & wdata[CC_EOP] & ~running;
  assign done_load = ~wr_en & pend & running & blk_done;
  assign load_now  = idle_load | done_load;

  always_comb begin
    ccr_d = ccr_q;
    if (wr_en) begin
      ccr_d = wdata;
      if (!running) ccr_d[CC_EOP] = 1'b0;
    end else if (blk_done && running) begin
      if (!rpt) ccr_d[CC_EN] = 1'b0;
      ccr_d[CC_EOP] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ccr_q <= RST_CHAN;
    else        ccr_q <= ccr_d;

  p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && blk_done && !wr_en && !rpt |=> !ccr_q[CC_EN]);
  p_repeat_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && blk_done && !wr_en && rpt |=> ccr_q[CC_EN]);
  p_eop_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && running && blk_done && !wr_en |=> !ccr_q[CC_EOP]);
  p_eop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && running && !blk_done && !wr_en |=> ccr_q[CC_EOP]);
endmodule

// File: rtl/dchan_disp.sv
module dchan_disp
  import dchan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          blk_done,
  output logic [DW-1:0] dctl_q,
  output logic          irq
);
  logic [DW-1:0] ctl_q;
  logic          st_q, st_d, clr;

  assign clr  = wr_en & wdata[DC_ST];
  assign st_d = f_status_next(st_q, clr, blk_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0;
      st_q  <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= wdata & ~(DW'(1) << DC_ST);
      st_q <= st_d;
    end

  always_comb begin
    dctl_q        = ctl_q;
    dctl_q[DC_ST] = st_q;
  end

  assign irq = st_q & ctl_q[DC_IE];

  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> dctl_q[DC_ST]);
  p_status_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[DC_ST] && !blk_done |=> !dctl_q[DC_ST]);
endmodule

// File: rtl/dchan_shadow.sv
module dchan_shadow
  import dchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [DW-1:0]      wdata,
  input  logic               load,
  output logic [2*DW-1:0]    prog_base,
  output logic [CNT_W-1:0]   prog_ecnt,
  output logic [CNT_W-1:0]   prog_fcnt,
  output logic [2*DW-1:0]    act_base,
  output logic [CNT_W-1:0]   act_ecnt,
  output logic [CNT_W-1:0]   act_fcnt
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prog_base <= '0;
      prog_ecnt <= '0;
      prog_fcnt <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_BASE_LO: prog_base[DW-1:0]    <= wdata;
        RA_BASE_HI: prog_base[2*DW-1:DW] <= wdata;
        RA_ECNT:    prog_ecnt            <= wdata[CNT_W-1:0];
        RA_FCNT:    prog_fcnt            <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_base <= '0;
      act_ecnt <= '0;
      act_fcnt <= '0;
    end else if (load) begin
      act_base <= prog_base;
      act_ecnt <= prog_ecnt;
      act_fcnt <= prog_fcnt;
    end

  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_base) && $stable(act_ecnt) && $stable(act_fcnt));
  p_act_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> act_base == $past(prog_base) && act_ecnt == $past(prog_ecnt));
endmodule

// File: rtl/dchan_ctl.sv
module dchan_ctl
  import dchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             blk_done,
  output logic             xfer_go,
  output logic [31:0]      act_base,
  output logic [CNT_W-1:0] act_ecnt,
  output logic [CNT_W-1:0] act_fcnt,
  output logic             irq
);
  localparam int BASE_W = 2 * DW;

  logic          wr;
  logic          wr_chan, wr_disp;
  logic [DW-1:0] ccr_q, dctl_q, dprm_q, lchn_q;
  logic          running, load_now;
  logic [BASE_W-1:0] prog_base;
  logic [CNT_W-1:0]  prog_ecnt, prog_fcnt;

  assign wr      = bus_sel & bus_we;
  assign wr_chan = wr & (bus_addr == RA_CHAN);
  assign wr_disp = wr & (bus_addr == RA_DISP);

  dchan_chan u_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_chan), .wdata(bus_wdata),
    .blk_done(blk_done), .ccr_q(ccr_q), .running(running), .load_now(load_now)
  );

  dchan_disp u_disp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_disp), .wdata(bus_wdata),
    .blk_done(blk_done), .dctl_q(dctl_q), .irq(irq)
  );

  dchan_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata),
    .load(load_now), .prog_base(prog_base), .prog_ecnt(prog_ecnt),
    .prog_fcnt(prog_fcnt), .act_base(act_base), .act_ecnt(act_ecnt),
    .act_fcnt(act_fcnt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dprm_q <= RST_DPRM;
      lchn_q <= RST_LCHN;
    end else if (wr) begin
      if (bus_addr == RA_DPRM) dprm_q <= bus_wdata;
      if (bus_addr == RA_LCHN) lchn_q <= bus_wdata;
    end

  assign xfer_go = running & dctl_q[DC_EXT];

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_CHAN:    bus_rdata = ccr_q;
      RA_DISP:    bus_rdata = dctl_q;
      RA_DPRM:    bus_rdata = dprm_q;
      RA_LCHN:    bus_rdata = lchn_q;
      RA_BASE_LO: bus_rdata = prog_base[DW-1:0];
      RA_BASE_HI: bus_rdata = prog_base[BASE_W-1:DW];
      RA_ECNT:    bus_rdata = DW'(prog_ecnt);
      default:    bus_rdata = DW'(prog_fcnt);
    endcase
  end

  p_go_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chan && !bus_wdata[CC_CLAIM] |=> !xfer_go);
endmodule

// File: tb/sim_dchan_ctl.sv
module sim_dchan_ctl;
  localparam int P = 10;
  localparam int NV = 44;
  // op: 0 write, 1 read check, 2 done pulse, 3 output check
  // output check sel: 0 {irq,go}, 1 base lo, 2 base hi, 3 elem, 4 frame
  function automatic logic [40:0] mk(int r, int op, int a, int d, int e);
    return {r[3:0], op[1:0], a[2:0], d[15:0], e[15:0]};
  endfunction

  localparam logic [40:0] VEC [NV] = '{
    mk(2,0,4,16'h1000,0), mk(2,0,5,16'h0008,0),        // R2 program set
    mk(2,0,6,16'h0140,0), mk(2,0,7,16'h00F0,0),
    mk(2,1,4,0,16'h1000), mk(2,1,7,0,16'h00F0),        // R2 readback
    mk(4,3,1,0,16'h0000),                              // R4 not yet loaded
    mk(4,0,0,16'h0B81,0), mk(4,1,0,0,16'h0381),        // R4 idle load
    mk(4,3,1,0,16'h1000), mk(4,3,2,0,16'h0008),
    mk(4,3,3,0,16'h0140), mk(4,3,4,0,16'h00F0),
    mk(3,3,0,0,16'h0000),                              // R3 ext off
    mk(3,0,1,16'h0102,0), mk(3,3,0,0,16'h0001),        // R3 go
    mk(5,0,4,16'h2000,0), mk(5,0,6,16'h0280,0),
    mk(5,0,0,16'h0B81,0), mk(5,1,0,0,16'h0B81),        // R5 held
    mk(5,3,1,0,16'h1000), mk(5,3,3,0,16'h0140),
    mk(5,2,0,0,0),
    mk(5,1,0,0,16'h0381), mk(5,3,1,0,16'h2000),        // R5 R6 after done
    mk(5,3,3,0,16'h0280), mk(9,3,0,0,16'h0003),        // R9
    mk(8,1,1,0,16'h010A),                              // R8 set
    mk(8,0,1,16'h0102,0), mk(8,1,1,0,16'h010A),        // R8 write 0 keeps
    mk(9,0,1,16'h0100,0), mk(9,3,0,0,16'h0001),        // R9 ie off
    mk(8,0,1,16'h0108,0), mk(8,1,1,0,16'h0100),        // R8 w1c
    mk(7,0,0,16'h0081,0), mk(7,2,0,0,0),
    mk(7,1,0,0,16'h0001), mk(7,3,0,0,16'h0000),        // R7 single
    mk(10,0,0,16'h0381,0), mk(10,3,0,0,16'h0001),
    mk(10,0,0,16'h0380,0), mk(10,3,0,0,16'h0000),      // R10 release
    mk(10,2,0,0,0), mk(10,1,0,0,16'h0380)
  };

  logic clk, rst_n, bus_sel, bus_we, blk_done, xfer_go, irq;
  logic [2:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata, act_ecnt, act_fcnt;
  logic [31:0] act_base;
  int total, bad;
  bit finished;

  dchan_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blk_done(blk_done), .xfer_go(xfer_go), .act_base(act_base),
    .act_ecnt(act_ecnt), .act_fcnt(act_fcnt), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(P/2) clk = ~clk;
  end

  task automatic check(int r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] outsel(logic [2:0] s);
    case (s)
      3'd0: return {30'b0, irq, xfer_go};
      3'd1: return {16'b0, act_base[15:0]};
      3'd2: return {16'b0, act_base[31:16]};
      3'd3: return {16'b0, act_ecnt};
      default: return {16'b0, act_fcnt};
    endcase
  endfunction

  task automatic idle();
    bus_sel = 0; bus_we = 0; blk_done = 0; bus_wdata = '0;
  endtask

  task automatic rd_check(int r, logic [2:0] a, logic [15:0] e);
    @(negedge clk); idle(); bus_addr = a;
    #(P/4) check(r, {16'b0, bus_rdata}, {16'b0, e});
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    idle(); bus_addr = 3'd0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd_check(1, 3'd0, 16'h5440);
    rd_check(1, 3'd1, 16'h0000);
    rd_check(1, 3'd2, 16'h9102);
    rd_check(1, 3'd3, 16'h0004);
    check(1, {act_base[15:0], act_ecnt}, 32'h0);
    check(1, {30'b0, irq, xfer_go}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] r; logic [1:0] op; logic [2:0] a; logic [15:0] d, e;
      {r, op, a, d, e} = VEC[i];
      @(negedge clk); idle(); bus_addr = a;
      if (op == 2'd0) begin bus_sel = 1; bus_we = 1; bus_wdata = d; end
      if (op == 2'd2) blk_done = 1;
      #(P/4);
      if (op == 2'd1) check(int'(r), {16'b0, bus_rdata}, {16'b0, e});
      if (op == 2'd3) check(int'(r), outsel(a), {16'b0, e});
    end

    // R2 plain registers
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd2; bus_wdata = 16'hABCD;
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd3; bus_wdata = 16'h0007;
    rd_check(2, 3'd2, 16'hABCD);
    rd_check(2, 3'd3, 16'h0007);
    // R8 set wins over clear in the same cycle
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd1;
    bus_wdata = 16'h0108; blk_done = 1;
    rd_check(8, 3'd1, 16'h0108);
    // R9 irq with enable and status
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd1; bus_wdata = 16'h0002;
    @(negedge clk); idle(); #(P/4);
    check(9, {31'b0, irq}, 32'h1);
    // R6 repeat over two blocks with ext on
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd1; bus_wdata = 16'h0100;
    @(negedge clk); idle(); bus_sel = 1; bus_we = 1; bus_addr = 3'd0; bus_wdata = 16'h0381;
    @(negedge clk); idle(); blk_done = 1;
    @(negedge clk); idle(); blk_done = 1;
    @(negedge clk); idle(); #(P/4);
    check(6, {31'b0, xfer_go}, 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(P * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule